// File: doc/BRIEF.md
# Timed Output Event Queue with Last-Entry Rewrite

This block queues output events for a real-time I/O channel. Each event carries a timestamp and a data word. An event is sent on the output port in the single cycle in which the external free-running time counter equals its timestamp. The block sits in the same clock domain as that counter, which is nominally a 125 MHz system clock. Because of this, a write whose time has already passed is reported in the same cycle as the write. The offending write can then be tied to a precise exception.

The newest write does not enter the queue at once. It waits in a one-entry staging slot, and while it waits software may overwrite it with a rewrite request. This is how two pulses are merged into one. The slot hands its entry to the queue at the latest when the entry comes within a fixed lockout margin of its deadline. A newer push also hands the slot's entry over early. After the handover the entry can no longer be rewritten. The staging slot is controlled by a two-state machine. In `STG_IDLE` the slot is empty. In `STG_HELD` it holds the newest entry.

The state machine has these transitions. `STG_IDLE` goes to `STG_HELD` on an accepted push. `STG_HELD` stays in `STG_HELD` on an accepted push (handover plus reload) or on an accepted rewrite. `STG_HELD` goes to `STG_IDLE` when the lockout deadline forces a handover with no push in the same cycle. `STG_HELD` also goes to `STG_IDLE` when a handover finds the queue with no room. The parameter `LOCKOUT` must be at least 1, and `DEPTH` at least 2. Writers are expected to issue timestamps in rising order.

Top module: `evq_event_fifo`

## Requirements
- R1: After reset, `ev_valid_o`, `underflow_o`, `replace_err_o` and `overflow_o` are 0, the staging slot is empty and the queue holds nothing.
- R2: A write, either a push or a rewrite, is late when `wr_ts_i <= now_i + LOCKOUT` (unsigned, no wrap). A late write raises `underflow_o` combinationally in that same cycle and is discarded without any other effect.
- R3: An accepted push (`wr_valid_i=1`, `wr_replace_i=0`, not late) loads the staging slot. If the slot already held an entry, that entry moves into the queue in the same cycle.
- R4: The queue's oldest entry is shown on `ev_valid_o`/`ev_ts_o`/`ev_data_o` for exactly the one cycle in which `now_i` equals its timestamp, and it leaves the queue in that cycle. Entries leave in the order they were written.
- R5: A rewrite (`wr_valid_i=1`, `wr_replace_i=1`, not late) while the slot holds an entry outside its lockout cycle replaces both the timestamp and the data of that entry. Only the new values are ever sent.
- R6: A non-late rewrite that arrives while the slot is empty, or in the cycle in which the staged entry reaches `stage_ts <= now_i + LOCKOUT`, raises `replace_err_o` in that cycle. The rewrite is dropped, and the staged entry is sent unchanged.
- R7: A staged entry moves into the queue in the first cycle in which its timestamp is `<= now_i + LOCKOUT`, even with no further writes.
- R8: If a handover is needed while the queue holds `DEPTH` entries and none leaves that cycle, `overflow_o` is set from the next cycle. The staged entry is discarded, any push of that cycle is dropped, and the slot becomes empty.
- R9: `overflow_o` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_i | input | TS_W | Free-running time counter value |
| wr_valid_i | input | 1 | Write request |
| wr_replace_i | input | 1 | 1: rewrite the staged entry, 0: push a new entry |
| wr_ts_i | input | TS_W | Timestamp of the write |
| wr_data_i | input | DATA_W | Data word of the write |
| ev_valid_o | output | 1 | Event due this cycle |
| ev_ts_o | output | TS_W | Timestamp of the oldest queued entry |
| ev_data_o | output | DATA_W | Data of the oldest queued entry |
| underflow_o | output | 1 | Current write is late (combinational) |
| replace_err_o | output | 1 | Current rewrite was refused (combinational) |
| overflow_o | output | 1 | Sticky: a handover found the queue full |

## Verification
The hardest case to reach is the boundary between an accepted rewrite and a refused one. It is a single cycle, fixed by the staged timestamp minus the lockout margin. The bench stages an entry a set distance ahead and then sweeps the cycle of the rewrite across that boundary. For each position it checks the error flag and also which data word finally appears, and when. The overflow case needs the queue full and a held entry at the same time. The bench gets there with a burst of back-to-back pushes whose timestamps are far ahead, so that nothing drains while the queue fills.

// File: rtl/evq_pkg.sv
package evq_pkg;

    // Staging slot states
    typedef enum logic [0:0] {
        STG_IDLE = 1'b0,   // slot empty
        STG_HELD = 1'b1    // slot holds the newest, still rewritable entry
    } stg_state_e;

endpackage

// File: rtl/evq_ring.sv
module evq_ring #(
    parameter int TS_W   = 16,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   now_i,
    input  logic              push_i,
    input  logic [TS_W-1:0]   push_ts_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic              room_o,
    output logic              ev_valid_o,
    output logic [TS_W-1:0]   ev_ts_o,
    output logic [DATA_W-1:0] ev_data_o
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [TS_W-1:0]   ts_mem   [DEPTH];
    logic [DATA_W-1:0] data_mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count;
    logic              pop;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    assign ev_ts_o    = ts_mem[rd_ptr];
    assign ev_data_o  = data_mem[rd_ptr];
    assign pop        = (count != '0) && (ts_mem[rd_ptr] == now_i);
    assign ev_valid_o = pop;
    assign room_o     = (count < FULL_CNT) || pop;

    always_ff @(posedge clk) begin
        if (push_i) begin
            ts_mem[wr_ptr]   <= push_ts_i;
            data_mem[wr_ptr] <= push_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i) wr_ptr <= next_ptr(wr_ptr);
            if (pop)    rd_ptr <= next_ptr(rd_ptr);
            unique case ({push_i, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/evq_stage.sv
module evq_stage
    import evq_pkg::*;
#(
    parameter int TS_W    = 16,
    parameter int DATA_W  = 8,
    parameter int LOCKOUT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   now_i,
    input  logic              wr_valid_i,
    input  logic              wr_replace_i,
    input  logic [TS_W-1:0]   wr_ts_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              room_i,
    output logic              commit_o,
    output logic [TS_W-1:0]   commit_ts_o,
    output logic [DATA_W-1:0] commit_data_o,
    output logic              underflow_o,
    output logic              replace_err_o,
    output logic              overflow_o
);

    localparam int EXT_W = TS_W + 1;

    stg_state_e        state, state_nxt;
    logic [TS_W-1:0]   stage_ts;
    logic [DATA_W-1:0] stage_data;
    logic [EXT_W-1:0]  horizon;
    logic              held, late, due, push_ok, rep_req, rep_ok;
    logic              commit_req, ovf_evt, load;

    // Deadline arithmetic, one bit wider so the margin cannot wrap
    assign horizon = {1'b0, now_i} + EXT_W'(LOCKOUT);
    assign held    = (state == STG_HELD);
    assign late    = wr_valid_i && ({1'b0, wr_ts_i} <= horizon);
    assign due     = held && ({1'b0, stage_ts} <= horizon);
    assign push_ok = wr_valid_i && !wr_replace_i && !late;
    assign rep_req = wr_valid_i &&  wr_replace_i && !late;
    assign rep_ok  = rep_req && held && !due;

    // Output process
    always_comb begin
        commit_req    = held && (due || push_ok);
        commit_o      = commit_req && room_i;
        ovf_evt       = commit_req && !room_i;
        underflow_o   = late;
        replace_err_o = rep_req && !rep_ok;
        commit_ts_o   = stage_ts;
        commit_data_o = stage_data;
    end

    // Next-state process
    always_comb begin
        state_nxt = state;
        load      = 1'b0;
        unique case (state)
            STG_IDLE: begin
                if (push_ok) begin
                    state_nxt = STG_HELD;
                    load      = 1'b1;
                end
            end
            STG_HELD: begin
                if (ovf_evt) begin
                    state_nxt = STG_IDLE;
                end else if (push_ok) begin
                    load = 1'b1;
                end else if (due) begin
                    state_nxt = STG_IDLE;
                end else if (rep_ok) begin
                    load = 1'b1;
                end
            end
            default: state_nxt = STG_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= STG_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_ts   <= '0;
            stage_data <= '0;
        end else if (load) begin
            stage_ts   <= wr_ts_i;
            stage_data <= wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       overflow_o <= 1'b0;
        else if (ovf_evt) overflow_o <= 1'b1;
    end

endmodule

// File: rtl/evq_event_fifo.sv
module evq_event_fifo #(
    parameter int TS_W    = 16,
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 4,
    parameter int LOCKOUT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   now_i,
    input  logic              wr_valid_i,
    input  logic              wr_replace_i,
    input  logic [TS_W-1:0]   wr_ts_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              ev_valid_o,
    output logic [TS_W-1:0]   ev_ts_o,
    output logic [DATA_W-1:0] ev_data_o,
    output logic              underflow_o,
    output logic              replace_err_o,
    output logic              overflow_o
);

    logic              commit;
    logic [TS_W-1:0]   commit_ts;
    logic [DATA_W-1:0] commit_data;
    logic              room;

    evq_stage #(
        .TS_W(TS_W), .DATA_W(DATA_W), .LOCKOUT(LOCKOUT)
    ) stage_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .now_i         (now_i),
        .wr_valid_i    (wr_valid_i),
        .wr_replace_i  (wr_replace_i),
        .wr_ts_i       (wr_ts_i),
        .wr_data_i     (wr_data_i),
        .room_i        (room),
        .commit_o      (commit),
        .commit_ts_o   (commit_ts),
        .commit_data_o (commit_data),
        .underflow_o   (underflow_o),
        .replace_err_o (replace_err_o),
        .overflow_o    (overflow_o)
    );

    evq_ring #(
        .TS_W(TS_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
    ) ring_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .now_i       (now_i),
        .push_i      (commit),
        .push_ts_i   (commit_ts),
        .push_data_i (commit_data),
        .room_o      (room),
        .ev_valid_o  (ev_valid_o),
        .ev_ts_o     (ev_ts_o),
        .ev_data_o   (ev_data_o)
    );

endmodule

// File: rtl/evq_event_fifo_chk.sv
module evq_event_fifo_chk #(
    parameter int TS_W   = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TS_W-1:0]   now_i,
    input logic              wr_valid_i,
    input logic              wr_replace_i,
    input logic              ev_valid_o,
    input logic [TS_W-1:0]   ev_ts_o,
    input logic              underflow_o,
    input logic              replace_err_o,
    input logic              overflow_o
);

    // R4: an event is only shown when the counter matches its timestamp
    p_ev_on_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_o |-> (ev_ts_o == now_i));

    // R2: lateness is only ever reported against an actual write
    p_uf_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> wr_valid_i);

    // R6: a refusal only answers a rewrite that was not late
    p_err_needs_rewrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        replace_err_o |-> (wr_valid_i && wr_replace_i && !underflow_o));

    // R9: overflow is sticky
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    // R1: first cycle out of reset has a clear overflow flag
    p_ovf_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> !overflow_o);

endmodule

bind evq_event_fifo evq_event_fifo_chk #(
    .TS_W(TS_W), .DATA_W(DATA_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .now_i         (now_i),
    .wr_valid_i    (wr_valid_i),
    .wr_replace_i  (wr_replace_i),
    .ev_valid_o    (ev_valid_o),
    .ev_ts_o       (ev_ts_o),
    .underflow_o   (underflow_o),
    .replace_err_o (replace_err_o),
    .overflow_o    (overflow_o)
);

// File: tb/evq_event_fifo_tb_top.sv
module evq_event_fifo_tb_top;

    localparam int TS_W = 16, DATA_W = 8, DEPTH = 4, LOCKOUT = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [TS_W-1:0]   now_i;
    logic              wr_valid_i, wr_replace_i;
    logic [TS_W-1:0]   wr_ts_i;
    logic [DATA_W-1:0] wr_data_i;
    logic              ev_valid_o, underflow_o, replace_err_o, overflow_o;
    logic [TS_W-1:0]   ev_ts_o;
    logic [DATA_W-1:0] ev_data_o;

    int n_tests = 0, n_fail = 0;
    int now = 0;
    int exp_ts [16];
    int exp_dat[16];
    int exp_n = 0;
    int last_uf, last_err;

    always #5 clk = ~clk;

    evq_event_fifo #(
        .TS_W(TS_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .LOCKOUT(LOCKOUT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .now_i(now_i),
        .wr_valid_i(wr_valid_i), .wr_replace_i(wr_replace_i),
        .wr_ts_i(wr_ts_i), .wr_data_i(wr_data_i),
        .ev_valid_o(ev_valid_o), .ev_ts_o(ev_ts_o), .ev_data_o(ev_data_o),
        .underflow_o(underflow_o), .replace_err_o(replace_err_o),
        .overflow_o(overflow_o)
    );

    task automatic check_eq(input string req, input string what, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s at now=%0d: actual %0d expected %0d", req, what, now, act, expv);
        end
    endtask

    task automatic add_exp(input int ts, input int d);
        exp_ts[exp_n]  = ts;
        exp_dat[exp_n] = d;
        exp_n++;
    endtask

    // One cycle: advance counter, drive a write, check the event port
    task automatic tick(input bit v, input bit rep, input int ts, input int d);
        int found, edata;
        @(negedge clk);
        now++;
        now_i        = TS_W'(now);
        wr_valid_i   = v;
        wr_replace_i = rep;
        wr_ts_i      = TS_W'(ts);
        wr_data_i    = DATA_W'(d);
        #1;
        found = 0; edata = 0;
        for (int i = 0; i < exp_n; i++)
            if (exp_ts[i] == now) begin found = 1; edata = exp_dat[i]; end
        check_eq("R4", "ev_valid", int'(ev_valid_o), found);
        if (found != 0) check_eq("R4", "ev_data", int'(ev_data_o), edata);
        last_uf  = int'(underflow_o);
        last_err = int'(replace_err_o);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; exp_n = 0; now = 0; now_i = '0;
        wr_valid_i = 1'b0; wr_replace_i = 1'b0; wr_ts_i = '0; wr_data_i = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int t;
        // R1: reset state
        do_reset();
        #1;
        check_eq("R1", "ev_valid", int'(ev_valid_o), 0);
        check_eq("R1", "overflow", int'(overflow_o), 0);
        check_eq("R1", "underflow", int'(underflow_o), 0);
        check_eq("R1", "replace_err", int'(replace_err_o), 0);

        // R2/R7: sweep write distance across the lateness boundary
        for (int delta = 0; delta <= 8; delta++) begin
            do_reset();
            t = now + 1;
            tick(1'b1, 1'b0, t + delta, 8'h40 + delta);
            check_eq("R2", "underflow", last_uf, (delta <= LOCKOUT) ? 1 : 0);
            if (delta > LOCKOUT) add_exp(t + delta, 8'h40 + delta);
            idle(delta + 3);
        end

        // R3/R4: chained pushes leave in order, one cycle each
        do_reset();
        t = now + 1;
        tick(1'b1, 1'b0, t + 10, 8'h11);
        tick(1'b1, 1'b0, t + 11, 8'h22);
        tick(1'b1, 1'b0, t + 13, 8'h33);
        check_eq("R3", "underflow", last_uf, 0);
        add_exp(t + 10, 8'h11); add_exp(t + 11, 8'h22); add_exp(t + 13, 8'h33);
        idle(16);

        // R5: rewrite replaces timestamp and data
        do_reset();
        t = now + 1;
        tick(1'b1, 1'b0, t + 10, 8'hA1);
        tick(1'b1, 1'b1, t + 14, 8'hB2);
        check_eq("R5", "replace_err", last_err, 0);
        add_exp(t + 14, 8'hB2);
        idle(18);

        // R6: rewrite with an empty slot is refused
        do_reset();
        t = now + 1;
        tick(1'b1, 1'b1, t + 20, 8'h77);
        check_eq("R6", "replace_err", last_err, 1);
        idle(25);

        // R6/R5/R7: sweep rewrite cycle across the lockout boundary
        for (int k = 1; k <= 7; k++) begin
            do_reset();
            t = now + 1;
            tick(1'b1, 1'b0, t + 10, 8'hC3);
            idle(k - 1);
            tick(1'b1, 1'b1, t + 20, 8'hD4);
            check_eq("R6", "replace_err", last_err, (k >= 10 - LOCKOUT) ? 1 : 0);
            if (k >= 10 - LOCKOUT) add_exp(t + 10, 8'hC3);
            else                   add_exp(t + 20, 8'hD4);
            idle(25);
        end

        // R8/R9: fill the queue and the slot, then one more push
        do_reset();
        t = now + 1;
        for (int i = 0; i < DEPTH + 2; i++) begin
            tick(1'b1, 1'b0, t + 40 + i, 8'h10 + i);
            check_eq("R8", "overflow before", int'(overflow_o), 0);
        end
        for (int i = 0; i < DEPTH; i++) add_exp(t + 40 + i, 8'h10 + i);
        tick(1'b1, 1'b1, t + 100, 8'hEE);
        check_eq("R8", "overflow set", int'(overflow_o), 1);
        check_eq("R8", "slot empty, rewrite refused", last_err, 1);
        idle(50);
        check_eq("R9", "overflow held", int'(overflow_o), 1);
        do_reset();
        #1;
        check_eq("R1", "overflow after reset", int'(overflow_o), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule